// File: doc/BRIEF.md
# Low-Frequency Reader Clock and ADC Serializer

This block sits between a 24 MHz master clock, an 8-bit analog-to-digital converter and a host processor in a low-frequency tag reader. A single half-period divider produces a square serial clock of about 1 MHz. From that clock it derives the carrier drive for the antenna coil drivers at 125 kHz or about 136 kHz, chosen by `rate_sel`, and a matching ADC sample clock. Because the serial clock and the carrier share one divider, every carrier period carries exactly one 8-bit sample.

The divider is a two-state machine, `PH_LOW` and `PH_HIGH`. It moves to the other phase at the terminal count of a 5-bit half-period counter. The counter reloads at that point with a length of 11 + `rate_sel` master cycles. A three-bit bit index advances on every falling serial clock edge. Its top bit is the carrier, so the ADC sample is captured when the carrier rises, and a new frame starts when the index wraps.

The serializer is a three-state machine. `SER_IDLE` moves to `SER_ARMED` on the first capture. `SER_ARMED` moves to `SER_SHIFT` at the next index wrap. `SER_SHIFT` stays there, reloading its shift register from the holding register at every wrap, so frames follow each other with no gap. The debug output mirrors the ADC clock, and the high-frequency drive output is held low.

Top module: `lf_carrier_serializer`

## Requirements
- R1: While `rst_sync` is high at a clock edge, all outputs read 0 after that edge. This holds both at power-up and when reset is applied in the middle of a run.
- R2: `ser_clk` is a square wave that starts low after reset. Each phase lasts 11 + `rate_sel` master cycles: 12 cycles when `rate_sel`=1 and 11 cycles when `rate_sel`=0. The first rise comes 11 + `rate_sel` edges after reset is released.
- R3: `rate_sel` is sampled only at a phase boundary of `ser_clk`. A phase in progress keeps the length that was chosen when it began.
- R4: `carrier_drv` changes only on a falling edge of `ser_clk`, once every 4 serial clock periods. It first rises at the 4th falling edge after reset.
- R5: `adc_clk` equals `carrier_drv`, `dbg_clk` equals `adc_clk`, and `hf_drv` is always 0.
- R6: `adc_sample` is captured only at the edge where `carrier_drv` rises. The captured byte is the one sent in the frame that starts at the next falling edge of `carrier_drv`. Changes of `adc_sample` while the carrier is high do not reach the output.
- R7: `ser_frame` rises at the first falling edge of `carrier_drv` that follows the first capture, which is the 8th falling serial clock edge after reset. After that it stays high until the next reset.
- R8: `ser_data` changes only on a falling edge of `ser_clk`. Sampled on successive rising edges of `ser_clk`, it carries 8 bits per frame with the most significant bit first, and frames follow each other back to back.
- R9: `ser_data` is 0 while `ser_frame` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | 24 MHz master clock |
| rst_sync | input | 1 | Synchronous reset, active high |
| rate_sel | input | 1 | Carrier select: 1 gives 125 kHz, 0 gives about 136 kHz |
| adc_sample | input | 8 | Parallel sample from the converter |
| carrier_drv | output | 1 | Carrier drive to the coil drivers |
| adc_clk | output | 1 | Sample clock to the converter, in phase with the carrier |
| ser_clk | output | 1 | Serial clock, about 1 MHz |
| ser_frame | output | 1 | Frame indicator, high while bytes are shifted |
| ser_data | output | 1 | Serial data, most significant bit first |
| dbg_clk | output | 1 | Debug copy of the ADC clock |
| hf_drv | output | 1 | High-frequency drive, held low |

## Verification
The bench changes `rate_sel` every few cycles, so many changes land in the middle of a serial clock phase. It then measures the length of every phase. A divider that applied the new rate straight away would produce a phase of the wrong length, either cut short or stretched. The bench also changes `adc_sample` to a different value just after each carrier rise. If the capture edge were misplaced, or the holding register were skipped, those values would appear in the received bytes and fail the scoreboard comparison. Finally, the bench times the first serial clock rise, the first carrier rise and the first frame from reset, both at start-up and after a reset in mid-run. A design that were off by one edge in its counters, or that started the frame before a sample was held, would miss those cycle counts.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } clk_phase_e;

    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_ARMED = 2'd1,
        SER_SHIFT = 2'd2
    } ser_state_e;
endpackage

// File: rtl/lfr_half_divider.sv
module lfr_half_divider
    import lfr_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int BASE_HALF = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic rate_sel,
    output logic ser_clk,
    output logic fall_evt
);
    localparam logic [CNT_W-1:0] BASE_L = CNT_W'(BASE_HALF);

    clk_phase_e       phase_q, phase_d;
    logic [CNT_W-1:0] hcnt_q, hlen_q, reload_len;
    logic             at_term;

    assign reload_len = BASE_L + CNT_W'(rate_sel);
    assign at_term    = (hcnt_q == hlen_q - CNT_W'(1));

    // next phase
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_LOW:  if (at_term) phase_d = PH_HIGH;
            PH_HIGH: if (at_term) phase_d = PH_LOW;
        endcase
    end

    // phase register
    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_LOW;
        else     phase_q <= phase_d;
    end

    // half-period counter, length latched only at reload
    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt_q <= '0;
            hlen_q <= reload_len;
        end else if (at_term) begin
            hcnt_q <= '0;
            hlen_q <= reload_len;
        end else begin
            hcnt_q <= hcnt_q + CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        ser_clk  = (phase_q == PH_HIGH);
        fall_evt = at_term && (phase_q == PH_HIGH);
    end

    assert_reload_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (hcnt_q != '0) |-> $stable(hlen_q));

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        hcnt_q < hlen_q);
endmodule

// File: rtl/lfr_carrier_seq.sv
module lfr_carrier_seq #(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic fall_evt,
    output logic carrier,
    output logic capture_stb,
    output logic frame_stb
);
    localparam int IDX_W    = $clog2(DATA_W);
    localparam int HALF_IDX = DATA_W / 2;

    logic [IDX_W-1:0] bidx_q, bidx_nx;
    logic             carrier_q;

    assign bidx_nx = bidx_q + IDX_W'(1);

    // bit index and carrier advance on falling serial clock edges
    always_ff @(posedge clk) begin
        if (rst) begin
            bidx_q    <= '0;
            carrier_q <= 1'b0;
        end else if (fall_evt) begin
            bidx_q    <= bidx_nx;
            carrier_q <= bidx_nx[IDX_W-1];
        end
    end

    always_comb begin
        carrier     = carrier_q;
        capture_stb = fall_evt && (bidx_nx == IDX_W'(HALF_IDX));
        frame_stb   = fall_evt && (bidx_q == IDX_W'(DATA_W - 1));
    end

    assert_carrier_step_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(carrier_q) |-> $past(fall_evt));

    assert_capture_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
        capture_stb |=> $rose(carrier_q));
endmodule

// File: rtl/lfr_serializer.sv
module lfr_serializer
    import lfr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_evt,
    input  logic              capture_stb,
    input  logic              frame_stb,
    input  logic [DATA_W-1:0] adc_sample,
    output logic              frame,
    output logic              data
);
    ser_state_e        state_q, state_d;
    logic [DATA_W-1:0] hold_q, shreg_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SER_IDLE:  if (capture_stb) state_d = SER_ARMED;
            SER_ARMED: if (frame_stb)   state_d = SER_SHIFT;
            SER_SHIFT: state_d = SER_SHIFT;
            default:   state_d = SER_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SER_IDLE;
        else     state_q <= state_d;
    end

    // holding register and shifter
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            shreg_q <= '0;
        end else begin
            if (capture_stb) hold_q <= adc_sample;
            if (frame_stb && state_q != SER_IDLE)
                shreg_q <= hold_q;
            else if (fall_evt && state_q == SER_SHIFT)
                shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
        end
    end

    // outputs
    always_comb begin
        frame = (state_q == SER_SHIFT);
        data  = (state_q == SER_SHIFT) ? shreg_q[DATA_W-1] : 1'b0;
    end

    assert_frame_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !$fell(frame));

    assert_frame_load_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(frame) |-> $past(frame_stb));
endmodule

// File: rtl/lf_carrier_serializer.sv
module lf_carrier_serializer #(
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 5,
    parameter int BASE_HALF = 11
) (
    input  logic              clk_main,
    input  logic              rst_sync,
    input  logic              rate_sel,
    input  logic [DATA_W-1:0] adc_sample,
    output logic              carrier_drv,
    output logic              adc_clk,
    output logic              ser_clk,
    output logic              ser_frame,
    output logic              ser_data,
    output logic              dbg_clk,
    output logic              hf_drv
);
    localparam int AGE_W = 6;

    logic fall_evt, capture_stb, frame_stb, carrier;

    lfr_half_divider #(
        .CNT_W     (CNT_W),
        .BASE_HALF (BASE_HALF)
    ) u_div (
        .clk      (clk_main),
        .rst      (rst_sync),
        .rate_sel (rate_sel),
        .ser_clk  (ser_clk),
        .fall_evt (fall_evt)
    );

    lfr_carrier_seq #(
        .DATA_W (DATA_W)
    ) u_car (
        .clk         (clk_main),
        .rst         (rst_sync),
        .fall_evt    (fall_evt),
        .carrier     (carrier),
        .capture_stb (capture_stb),
        .frame_stb   (frame_stb)
    );

    lfr_serializer #(
        .DATA_W (DATA_W)
    ) u_ser (
        .clk         (clk_main),
        .rst         (rst_sync),
        .fall_evt    (fall_evt),
        .capture_stb (capture_stb),
        .frame_stb   (frame_stb),
        .adc_sample  (adc_sample),
        .frame       (ser_frame),
        .data        (ser_data)
    );

    always_comb begin
        carrier_drv = carrier;
        adc_clk     = carrier;
        dbg_clk     = carrier;
        hf_drv      = 1'b0;
    end

    // phase-age tracker for the minimum phase length check
    logic             sclk_d, age_valid;
    logic [AGE_W-1:0] age;

    always_ff @(posedge clk_main) begin
        if (rst_sync) begin
            sclk_d    <= 1'b0;
            age       <= '0;
            age_valid <= 1'b0;
        end else begin
            sclk_d <= ser_clk;
            if (ser_clk != sclk_d) begin
                age       <= AGE_W'(1);
                age_valid <= 1'b1;
            end else if (age != '1) begin
                age <= age + AGE_W'(1);
            end
        end
    end

    assert_min_phase_R2: assert property (@(posedge clk_main) disable iff (rst_sync)
        (ser_clk != sclk_d && age_valid) |-> (age >= AGE_W'(BASE_HALF)));

    assert_data_on_fall_R8: assert property (@(posedge clk_main) disable iff (rst_sync)
        !$stable(ser_data) |-> $fell(ser_clk));

    assert_frame_on_carrier_fall_R7: assert property (@(posedge clk_main) disable iff (rst_sync)
        $rose(ser_frame) |-> $fell(carrier_drv));
endmodule

// File: tb/sim_lf_carrier_serializer.sv
`timescale 1ns/1ps
module sim_lf_carrier_serializer;
    localparam int DATA_W    = 8;
    localparam int CNT_W     = 5;
    localparam int BASE_HALF = 11;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rate_sel = 1'b1;
    logic [DATA_W-1:0] adc_sample = '0;
    logic carrier_drv, adc_clk, ser_clk, ser_frame, ser_data, dbg_clk, hf_drv;

    lf_carrier_serializer #(
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .BASE_HALF (BASE_HALF)
    ) u0 (
        .clk_main    (clk),
        .rst_sync    (rst),
        .rate_sel    (rate_sel),
        .adc_sample  (adc_sample),
        .carrier_drv (carrier_drv),
        .adc_clk     (adc_clk),
        .ser_clk     (ser_clk),
        .ser_frame   (ser_frame),
        .ser_data    (ser_data),
        .dbg_clk     (dbg_clk),
        .hf_drv      (hf_drv)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_err = 0, n_bytes = 0;
    bit done = 1'b0;
    bit drv_run = 1'b0;
    logic [DATA_W-1:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    // driver: one byte per carrier period, junk while the carrier is high
    task automatic drive_bytes(input logic [DATA_W-1:0] seed);
        logic [DATA_W-1:0] v = seed;
        while (drv_run) begin
            @(negedge clk);
            while (carrier_drv !== 1'b0) @(negedge clk);
            adc_sample = v;
            exp_q.push_back(v);
            while (carrier_drv !== 1'b1) @(negedge clk);
            adc_sample = ~v ^ 8'h5a;  // R6: must never be sent
            v = v * 8'd5 + 8'd59;
        end
    endtask

    // monitor / scoreboard
    logic p_sclk = 0, p_car = 0, p_data = 0, p_frame = 0, p_sel = 1, len_sel = 1;
    int half_cnt = 0, falls = 0, nb = 0;
    bit tog_seen = 0;
    logic [DATA_W-1:0] acc = '0;

    always @(negedge clk) begin
        if (rst) begin
            p_sclk = 0; p_car = 0; p_data = 0; p_frame = 0;
            half_cnt = 0; falls = 0; nb = 0; tog_seen = 0; acc = '0;
        end else begin
            chk(adc_clk === carrier_drv && dbg_clk === adc_clk && hf_drv === 1'b0,
                "R5 clock copies", {adc_clk, dbg_clk, hf_drv}, {carrier_drv, carrier_drv, 1'b0});
            if (ser_clk !== p_sclk) begin
                if (tog_seen)
                    chk(half_cnt == BASE_HALF + int'(len_sel), "R3 phase length",
                        half_cnt, BASE_HALF + int'(len_sel));
                len_sel  = p_sel;
                tog_seen = 1;
                half_cnt = 1;
                if (p_sclk && !ser_clk) falls++;
            end else begin
                half_cnt++;
            end
            if (ser_data !== p_data)
                chk(p_sclk === 1'b1 && ser_clk === 1'b0, "R8 data edge", ser_clk, 0);
            if (carrier_drv !== p_car) begin
                chk(falls == 4, "R4 carrier step", falls, 4);
                falls = 0;
            end
            if (ser_frame && !p_frame)
                chk(p_car === 1'b1 && carrier_drv === 1'b0, "R7 frame start", carrier_drv, 0);
            if (!ser_frame && p_frame)
                chk(1'b0, "R7 frame dropped", 0, 1);
            if (!ser_frame)
                chk(ser_data === 1'b0, "R9 idle data", ser_data, 0);
            if (ser_frame && ser_clk && !p_sclk) begin
                acc = {acc[DATA_W-2:0], ser_data};
                nb++;
                if (nb == DATA_W) begin
                    nb = 0;
                    if (exp_q.size() > 0) begin
                        logic [DATA_W-1:0] e;
                        e = exp_q.pop_front();
                        chk(acc == e, "R6 R8 byte", acc, e);
                        n_bytes++;
                    end
                end
            end
            p_sclk = ser_clk; p_car = carrier_drv; p_data = ser_data; p_frame = ser_frame;
        end
        p_sel = rate_sel;
    end

    task automatic check_reset_outputs();
        chk({carrier_drv, adc_clk, ser_clk, ser_frame, ser_data, dbg_clk, hf_drv} === 7'b0,
            "R1 reset outputs",
            {carrier_drv, adc_clk, ser_clk, ser_frame, ser_data, dbg_clk, hf_drv}, 0);
    endtask

    task automatic release_and_time(input logic s);
        int k = 0, t_rise = 0, t_car = 0, t_frm = 0;
        int h = BASE_HALF + int'(s);
        @(posedge clk); #1 rst = 1'b0;
        while (t_frm == 0 && k < 1000) begin
            @(negedge clk);
            if (t_rise == 0 && ser_clk)     t_rise = k;
            if (t_car == 0 && carrier_drv)  t_car = k;
            if (t_frm == 0 && ser_frame)    t_frm = k;
            k++;
        end
        chk(t_rise == h, "R2 first rise", t_rise, h);
        chk(t_car == 8 * h, "R4 first carrier", t_car, 8 * h);
        chk(t_frm == 16 * h, "R7 first frame", t_frm, 16 * h);
    endtask

    task automatic set_sel(input logic s);
        @(posedge clk); #1 rate_sel = s;
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_outputs();
        drv_run = 1'b1;
        fork
            drive_bytes(8'h3c);
        join_none
        release_and_time(1'b1);
        repeat (12 * 192) @(negedge clk);
        set_sel(1'b0);
        repeat (12 * 176) @(negedge clk);
        for (int i = 0; i < 60; i++) begin
            set_sel(~rate_sel);
            repeat (37) @(posedge clk);
        end
        for (int i = 0; i < 40; i++) begin
            set_sel(~rate_sel);
            repeat (5) @(posedge clk);
        end
        set_sel(1'b0);
        repeat (6 * 176) @(negedge clk);
        drv_run = 1'b0;
        for (int i = 0; i < 2000 && exp_q.size() > 0; i++) @(negedge clk);
        chk(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);
        chk(n_bytes >= 30, "R6 byte count", n_bytes, 30);
        // reset in mid-run
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_reset_outputs();
        repeat (2) @(posedge clk);
        release_and_time(1'b0);
        repeat (200) @(negedge clk);
        summary();
        $finish;
    end
endmodule